// File: doc/BRIEF.md
# Differential/Gray Pixel Stream Decoder

This block sits on the receive side of a coded 10-bit pixel link. The sender can make two changes to the stream to cut down how many output bits toggle at once. It can Gray-code each word. It can also send each pixel as the difference from the pixel two samples before it. The decoder takes the coded word, a reference-strobe marker and the two mode controls. It returns one absolute binary pixel on every clock.

The word first passes through an optional Gray-to-binary unfold. In differential mode the binary word is then added, modulo 1024, to the decoded pixel from two clocks earlier. When the reference strobe is high, the absolute word is loaded as it is, and that phase is re-seeded.

The two-clock feedback is built as two accumulators, one for each interleaved sample phase. A two-state phase machine chooses between them:

- `PH_EVEN` moves to `PH_ODD` on every clock.
- `PH_ODD` moves to `PH_EVEN` on every clock.
- Reset enters `PH_EVEN`.

In each state, the matching accumulator supplies the history term and takes the new decoded pixel.

Top module: `pxd_decoder`

## Requirements
- R1: While `rst_n` is low, `pix_out` is 0, both phase histories are cleared to 0 and the phase machine is in `PH_EVEN`. A differential word sent right after reset therefore decodes to the word itself.
- R2: When `gray_en` is 1, the input is read as reflected Gray code. Binary bit i is the XOR of input bits 9 down to i, with bit 9 as the MSB.
- R3: When `diff_en` is 0 and `ref_strobe` is 0, `pix_out` equals the converted word one clock after the word is sampled.
- R4: When `diff_en` is 1 and `ref_strobe` is 0, `pix_out` equals the converted word plus the `pix_out` value two clocks earlier. It appears one clock after sampling.
- R5: The sum in R4 is taken modulo 1024, and any carry out of bit 9 is dropped.
- R6: When `ref_strobe` is 1, `pix_out` equals the converted word one clock later, whatever `diff_en` is set to and whatever the history holds.
- R7: The history term is the decoded output, not the raw input. A wrong pixel on one phase does not change decoding on the other phase, and a reference on that phase restores it.
- R8: The mode inputs may change on any clock. A differential word that follows pass-through words builds on the decoded pixels of those words.
- R9: The phase machine alternates between `PH_EVEN` and `PH_ODD` on every clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_in | input | 10 | Coded pixel word |
| ref_strobe | input | 1 | Loads the absolute reference word |
| gray_en | input | 1 | Input is Gray coded |
| diff_en | input | 1 | Input is a two-sample difference |
| pix_out | output | 10 | Decoded binary pixel |

## Verification
Each decoded pixel appears on `pix_out` one clock after its coded word is sampled. The history term it adds is the `pix_out` value two clocks before that pixel. The bench drives each word on a falling edge and reads the result on the next falling edge, one rising edge later. Its bench-side encoder builds every differential word from the pixels it expects two samples back.

// File: rtl/pxd_pkg.sv
package pxd_pkg;
    // Interleaved sample phases handled by the two-clock feedback
    typedef enum logic [0:0] {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_e;

    localparam int NUM_PHASES = 2;
endpackage

// File: rtl/pxd_gray_unfold.sv
module pxd_gray_unfold #(
    parameter int W = 10
) (
    input  logic         gray_en,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] word_out
);
    logic [W-1:0] prefix;

    // Running XOR from the MSB downward
    assign prefix[W-1] = word_in[W-1];
    generate
        for (genvar i = W - 2; i >= 0; i--) begin : g_fold
            assign prefix[i] = prefix[i+1] ^ word_in[i];
        end
    endgenerate

    assign word_out = gray_en ? prefix : word_in;
endmodule

// File: rtl/pxd_phase_fsm.sv
module pxd_phase_fsm
    import pxd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase_q,
    output logic   sel_even,
    output logic   sel_odd
);
    phase_e phase_d;

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_EVEN;
        else        phase_q <= phase_d;
    end

    always_comb begin
        unique case (phase_q)
            PH_EVEN: phase_d = PH_ODD;
            PH_ODD:  phase_d = PH_EVEN;
            default: phase_d = PH_EVEN;
        endcase
    end

    always_comb begin
        sel_even = 1'b0;
        sel_odd  = 1'b0;
        unique case (phase_q)
            PH_EVEN: sel_even = 1'b1;
            PH_ODD:  sel_odd  = 1'b1;
            default: sel_even = 1'b1;
        endcase
    end
endmodule

// File: rtl/pxd_recon.sv
module pxd_recon
    import pxd_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] conv_word,
    input  logic         ref_strobe,
    input  logic         diff_en,
    input  logic         sel_even,
    input  logic         sel_odd,
    output logic [W-1:0] pix_q
);
    logic [NUM_PHASES-1:0][W-1:0] hist_q;
    logic [NUM_PHASES-1:0]        wr_sel;
    logic [W-1:0]                 base;
    logic [W-1:0]                 sum;
    logic [W-1:0]                 result;

    assign wr_sel = {sel_odd, sel_even};
    assign base   = sel_odd ? hist_q[1] : hist_q[0];
    assign sum    = conv_word + base;   // carry beyond bit W-1 dropped

    always_comb begin
        if (ref_strobe)   result = conv_word;
        else if (diff_en) result = sum;
        else              result = conv_word;
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PHASES; p++) begin
            if (!rst_n)        hist_q[p] <= '0;
            else if (wr_sel[p]) hist_q[p] <= result;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pix_q <= '0;
        else        pix_q <= result;
    end
endmodule

// File: rtl/pxd_decoder.sv
module pxd_decoder
    import pxd_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] code_in,
    input  logic             ref_strobe,
    input  logic             gray_en,
    input  logic             diff_en,
    output logic [PIX_W-1:0] pix_out
);
    logic [PIX_W-1:0] conv_word;
    phase_e           phase_q;
    logic             sel_even;
    logic             sel_odd;

    pxd_gray_unfold #(.W(PIX_W)) u_unfold (
        .gray_en (gray_en),
        .word_in (code_in),
        .word_out(conv_word)
    );

    pxd_phase_fsm u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_q (phase_q),
        .sel_even(sel_even),
        .sel_odd (sel_odd)
    );

    pxd_recon #(.W(PIX_W)) u_recon (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_word (conv_word),
        .ref_strobe(ref_strobe),
        .diff_en   (diff_en),
        .sel_even  (sel_even),
        .sel_odd   (sel_odd),
        .pix_q     (pix_out)
    );
endmodule

// File: rtl/pxd_decoder_chk.sv
module pxd_decoder_chk
    import pxd_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PIX_W-1:0] code_in,
    input logic             ref_strobe,
    input logic             gray_en,
    input logic             diff_en,
    input logic [PIX_W-1:0] pix_out,
    input phase_e           phase
);
    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (!rst_n)        cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pix_out == '0 && phase == PH_EVEN));

    // R9
    phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1) |-> (phase != $past(phase)));

    // R3
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_strobe && !diff_en && !gray_en) |=> (pix_out == $past(code_in)));

    // R2
    gray_unfold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ref_strobe || !diff_en) && gray_en) |=> ((pix_out ^ (pix_out >> 1)) == $past(code_in)));

    // R6
    ref_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_strobe && !gray_en) |=> (pix_out == $past(code_in)));

    // R4 R5
    diff_accum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && diff_en && !ref_strobe && !gray_en)
        |=> (pix_out == PIX_W'($past(code_in) + $past(pix_out, 2))));
endmodule

bind pxd_decoder pxd_decoder_chk #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_in   (code_in),
    .ref_strobe(ref_strobe),
    .gray_en   (gray_en),
    .diff_en   (diff_en),
    .pix_out   (pix_out),
    .phase     (phase_q)
);

// File: tb/sim_pxd_decoder.sv
module sim_pxd_decoder;
    localparam int CLK_P = 10;
    localparam int W     = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] code_in = '0;
    logic         ref_strobe = 1'b0;
    logic         gray_en = 1'b0;
    logic         diff_en = 1'b0;
    logic [W-1:0] pix_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [W-1:0] e1 = '0;
    logic [W-1:0] e2 = '0;

    pxd_decoder #(.PIX_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .code_in(code_in), .ref_strobe(ref_strobe),
        .gray_en(gray_en), .diff_en(diff_en), .pix_out(pix_out)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    task automatic check(input logic [W-1:0] exp, input string req);
        checks++;
        if (pix_out !== exp) begin
            errors++;
            $display("FAIL %s: pix_out=%0d expected=%0d", req, pix_out, exp);
        end
    endtask

    // Drive one raw word, wait one rising edge, check on falling edge
    task automatic step(input logic [W-1:0] code, input bit rf, input bit gr,
                        input bit df, input logic [W-1:0] exp, input string req);
        code_in = code; ref_strobe = rf; gray_en = gr; diff_en = df;
        @(posedge clk);
        @(negedge clk);
        check(exp, req);
        e2 = e1;
        e1 = exp;
    endtask

    // Encode an absolute sample the way the sender would, then decode it
    task automatic send(input logic [W-1:0] s, input bit rf, input bit gr,
                        input bit df, input string req);
        logic [W-1:0] v;
        v = (rf || !df) ? s : W'(s - e2);
        step(gr ? to_gray(v) : v, rf, gr, df, s, req);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] s;
        void'($urandom(32'h5EED_0A1B));
        // R1 reset state
        code_in = 10'h3FF; diff_en = 1'b1; ref_strobe = 1'b1;
        repeat (3) @(negedge clk);
        check('0, "R1");
        rst_n = 1'b1;
        e1 = '0; e2 = '0;
        // R1: history cleared, so a difference word decodes to itself
        step(10'd37, 1'b0, 1'b0, 1'b1, 10'd37, "R1");
        step(10'd12, 1'b0, 1'b0, 1'b1, 10'd12, "R1");
        // R3 pass-through, R2 gray pass-through
        step(10'd700, 1'b0, 1'b0, 1'b0, 10'd700, "R3");
        step(to_gray(10'd513), 1'b0, 1'b1, 1'b0, 10'd513, "R2");
        step(to_gray(10'd1023), 1'b0, 1'b1, 1'b0, 10'd1023, "R2");
        // R5 wrap through 1023 -> 0
        send(10'd1020, 1'b1, 1'b0, 1'b1, "R6");
        send(10'd1021, 1'b1, 1'b0, 1'b1, "R6");
        send(10'd1022, 1'b0, 1'b0, 1'b1, "R5");
        send(10'd1023, 1'b0, 1'b0, 1'b1, "R5");
        send(10'd2,    1'b0, 1'b0, 1'b1, "R5");
        send(10'd5,    1'b0, 1'b0, 1'b1, "R5");
        // R4 downward wrap with Gray coding of the difference
        send(10'd1010, 1'b0, 1'b1, 1'b1, "R4");
        send(10'd1000, 1'b0, 1'b1, 1'b1, "R4");
        // R7: a bad word on one phase leaves the other intact; reference heals it
        send(10'd100, 1'b1, 1'b0, 1'b1, "R6");
        send(10'd200, 1'b1, 1'b0, 1'b1, "R6");
        step(10'd50, 1'b0, 1'b0, 1'b1, 10'd150, "R4");
        send(10'd210, 1'b0, 1'b0, 1'b1, "R7");
        send(10'd300, 1'b1, 1'b0, 1'b1, "R6");
        send(10'd305, 1'b0, 1'b0, 1'b1, "R7");
        send(10'd310, 1'b0, 1'b0, 1'b1, "R7");
        // R8: pass-through then switch to differential
        send(10'd444, 1'b0, 1'b1, 1'b0, "R8");
        send(10'd450, 1'b0, 1'b0, 1'b0, "R8");
        send(10'd447, 1'b0, 1'b0, 1'b1, "R8");
        send(10'd455, 1'b0, 1'b1, 1'b1, "R8");
        // Random smooth ramps in every mode combination, with strobes
        s = e1;
        for (int blk = 0; blk < 8; blk++) begin
            bit gr;
            bit df;
            gr = blk[0];
            df = blk[1];
            for (int i = 0; i < 200; i++) begin
                int delta;
                bit rf;
                delta = int'($urandom_range(16)) - 8;
                s = W'(int'(s) + delta);
                rf = ($urandom_range(31) == 0);
                if ($urandom_range(15) == 0) gr = ~gr;
                send(s, rf, gr, df, df ? "R4" : "R3");
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule